// File: doc/BRIEF.md
# Flash Converter Thermometer-to-Binary Decoder

This block is the digital back end of an N-bit flash converter. It receives the 2^N-1 latched comparator decisions as a thermometer vector. It turns them into an N-bit binary sample in two half-cycle stages. On the falling edge of the sampling clock, the first stage registers a Gray code that it forms directly from the thermometer taps. During the following low phase, the second stage converts that Gray code to binary. It loads the result into the output register on the next rising edge.

Because neighbouring Gray codes differ in a single bit, a wrong decision from the comparator at the input level moves the final sample by at most one step. A selectable comparison path uses the classic decoder instead. That path marks each 1-to-0 boundary with an AND gate and ORs together the indices of the marked boundaries. It lets the large errors produced by a broken thermometer be observed. The comparators, the reference ladder and any bubble correction sit outside this block.

Top module: `flash_gray_decoder`

## Requirements
- R1: The input has 2^N-1 bits, where bit i is the decision of the comparator whose threshold is i+1 steps above zero. The all-zero vector decodes to 0, and the all-one vector decodes to 2^N-1.
- R2: In Gray mode (`naive_sel`=0), a well-formed thermometer vector that holds m ones in bits 0..m-1 and zeros above them decodes to the binary value m.
- R3: The first stage registers its code on the falling clock edge. In Gray mode, the parity of the registered code equals the parity of the number of ones in the captured vector.
- R4: The second stage converts Gray code to binary by a prefix XOR, in which binary bit i is the XOR of Gray bits N-1 down to i. Re-encoding the output as b XOR (b>>1) gives back the captured Gray code.
- R5: A vector that is held across the high phase of cycle k and captured at the falling edge of cycle k appears at `bin_out` after the rising edge that starts cycle k+1. It then stays unchanged until the next rising edge. Every captured sample yields exactly one output.
- R6: While `rst_n` is low at a clock edge, both stages clear, `bin_out` reads 0 and `bin_valid` reads 0. After release, `bin_valid` first rises on the rising edge that follows the first falling-edge capture.
- R7: In comparison mode (`naive_sel`=1), the output is the bitwise OR of (i+1) over every i with t[i]=1 and t[i+1]=0, where the bit above the top is taken as 0. A well-formed vector therefore decodes to its count of ones. A gap just below the top 1 near mid-scale gives an error of about half of full scale.
- R8: In Gray mode, a single wrong decision at the transition changes the output by at most 1 step. Here the wrong decision is either the top 1 cleared or the lowest 0 set.
- R9: `naive_sel` is sampled on the same falling edge as the data. Each sample is decoded in the mode in force at its own capture, even when the mode changes every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; high = comparators held, low = tracking |
| rst_n | input | 1 | Synchronous reset, active low |
| naive_sel | input | 1 | 0 = Gray decoding path, 1 = AND/OR comparison path |
| thermo | input | 2^N-1 | Latched comparator decisions, bit 0 = lowest threshold |
| bin_out | output | N | Binary sample |
| bin_valid | output | 1 | High when `bin_out` carries a decoded sample |

## Verification
Two events can fall in the same clock period. The falling-edge stage captures a new vector and mode, while the rising-edge stage is still finishing the previous sample, which may have been captured in the other mode. The bench provokes this by toggling `naive_sel` every cycle. It sends well-formed vectors in Gray mode and vectors with a gap in comparison mode, where the two decoders give clearly different answers. The scoreboard holds the expected value of each sample together with its own mode. A mode that lags or leaks between stages therefore shows up as a mismatch on that sample.

// File: rtl/flash_dec_pkg.sv
package flash_dec_pkg;

    localparam int unsigned CODE_W_MIN = 3;
    localparam int unsigned CODE_W_MAX = 8;

    typedef logic [CODE_W_MAX-1:0] code_max_t;

    // Prefix XOR from the top bit downwards: binary bit i = XOR of Gray bits MAX-1..i.
    function automatic code_max_t gray_to_bin(input code_max_t g);
        code_max_t b;
        logic      acc;
        acc = 1'b0;
        b   = '0;
        for (int i = CODE_W_MAX - 1; i >= 0; i--) begin
            acc  = acc ^ g[i];
            b[i] = acc;
        end
        return b;
    endfunction

endpackage

// File: rtl/thermo_to_gray.sv
module thermo_to_gray #(
    parameter int unsigned N = 6
) (
    input  logic [(2**N)-2:0] thermo_i,
    output logic [N-1:0]      gray_o
);
    localparam int unsigned TAPS = (2**N) - 1;

    // Gray bit k collects the taps whose 1-based position is an odd multiple of 2^k.
    always_comb begin
        gray_o = '0;
        for (int k = 0; k < N; k++) begin
            for (int p = 1; p <= TAPS; p++) begin
                if ((p % (2 << k)) == (1 << k)) begin
                    gray_o[k] = gray_o[k] ^ thermo_i[p-1];
                end
            end
        end
    end

endmodule

// File: rtl/thermo_to_naive.sv
module thermo_to_naive #(
    parameter int unsigned N = 6
) (
    input  logic [(2**N)-2:0] thermo_i,
    input  logic              legal_i,
    output logic [N-1:0]      code_o
);
    localparam int unsigned TAPS = (2**N) - 1;

    logic [TAPS:0]   ext_w;
    logic [TAPS-1:0] edge_w;

    always_comb begin
        ext_w  = {1'b0, thermo_i};
        edge_w = '0;
        code_o = '0;
        for (int i = 0; i < TAPS; i++) begin
            edge_w[i] = ext_w[i] & ~ext_w[i+1];
            if (edge_w[i]) begin
                code_o = code_o | N'(i + 1);
            end
        end
    end

    // R7: a well-formed vector marks at most one boundary
    always_comb begin
        if (legal_i) begin
            a_r7_single_edge: assert ($onehot0(edge_w))
                else $error("comparison path marked several boundaries on a well-formed vector");
        end
    end

endmodule

// File: rtl/fall_capture.sv
module fall_capture #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         naive_sel_i,
    input  logic [N-1:0] gray_i,
    input  logic [N-1:0] naive_i,
    output logic         cap_valid_o,
    output logic         cap_naive_o,
    output logic [N-1:0] cap_code_o
);
    typedef struct packed {
        logic         valid;
        logic         naive;
        logic [N-1:0] code;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (!rst_n) begin
            cap_d = '0;
        end else begin
            cap_d.valid = 1'b1;
            cap_d.naive = naive_sel_i;
            cap_d.code  = naive_sel_i ? naive_i : gray_i;
        end
    end

    always_ff @(negedge clk) begin
        cap_q <= cap_d;
    end

    assign cap_valid_o = cap_q.valid;
    assign cap_naive_o = cap_q.naive;
    assign cap_code_o  = cap_q.code;

    // R9: the registered mode follows the select seen at the capturing edge
    a_r9_mode_capture: assert property (@(negedge clk) disable iff (!rst_n)
        1'b1 |=> (cap_q.naive == $past(naive_sel_i)))
        else $error("captured mode differs from select at capture");

endmodule

// File: rtl/rise_output.sv
module rise_output
    import flash_dec_pkg::*;
#(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_valid_i,
    input  logic         cap_naive_i,
    input  logic [N-1:0] cap_code_i,
    output logic         out_valid_o,
    output logic [N-1:0] out_data_o
);
    typedef struct packed {
        logic         valid;
        logic [N-1:0] data;
    } out_t;

    out_t out_d, out_q;
    logic [N-1:0] conv_w;

    always_comb begin
        conv_w = N'(gray_to_bin(code_max_t'(cap_code_i)));
        out_d  = out_q;
        if (!rst_n) begin
            out_d = '0;
        end else begin
            out_d.valid = cap_valid_i;
            out_d.data  = cap_naive_i ? cap_code_i : conv_w;
        end
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign out_valid_o = out_q.valid;
    assign out_data_o  = out_q.data;

    // R4: re-encoding the binary output returns the Gray code it came from
    a_r4_gray_roundtrip: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid_i && !cap_naive_i) |=> ((out_q.data ^ (out_q.data >> 1)) == $past(cap_code_i)))
        else $error("binary output does not re-encode to captured Gray code");

    // R6: no valid output without a captured sample behind it
    a_r6_valid_needs_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_valid_i |=> !out_q.valid)
        else $error("output marked valid without a capture");

endmodule

// File: rtl/flash_gray_decoder.sv
module flash_gray_decoder #(
    parameter int unsigned N = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               naive_sel,
    input  logic [(2**N)-2:0]  thermo,
    output logic [N-1:0]       bin_out,
    output logic               bin_valid
);
    localparam int unsigned TAPS = (2**N) - 1;

    logic [N-1:0] gray_w;
    logic [N-1:0] naive_w;
    logic         legal_w;
    logic         cap_valid_w;
    logic         cap_naive_w;
    logic [N-1:0] cap_code_w;

    // well-formed: ones packed at the bottom, so adding one clears every set bit
    assign legal_w = ((thermo & (thermo + TAPS'(1))) == '0);

    thermo_to_gray #(.N(N)) u_gray (
        .thermo_i (thermo),
        .gray_o   (gray_w)
    );

    thermo_to_naive #(.N(N)) u_naive (
        .thermo_i (thermo),
        .legal_i  (legal_w),
        .code_o   (naive_w)
    );

    fall_capture #(.N(N)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .naive_sel_i (naive_sel),
        .gray_i      (gray_w),
        .naive_i     (naive_w),
        .cap_valid_o (cap_valid_w),
        .cap_naive_o (cap_naive_w),
        .cap_code_o  (cap_code_w)
    );

    rise_output #(.N(N)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_valid_i (cap_valid_w),
        .cap_naive_i (cap_naive_w),
        .cap_code_i  (cap_code_w),
        .out_valid_o (bin_valid),
        .out_data_o  (bin_out)
    );

    // R3: Gray parity tracks the number of ones in the captured vector
    a_r3_gray_parity: assert property (@(negedge clk) disable iff (!rst_n)
        (legal_w && !naive_sel) |=> ((^cap_code_w) == $past(^thermo)))
        else $error("captured Gray parity disagrees with thermometer count");

endmodule

// File: tb/sim_flash_gray_decoder.sv
module sim_flash_gray_decoder;

    localparam int unsigned N          = 6;
    localparam int unsigned TAPS       = (2**N) - 1;
    localparam int unsigned FULL       = (2**N) - 1;
    localparam int          CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            naive_sel = 1'b0;
    logic [TAPS-1:0] thermo = '1;
    logic [N-1:0]    bin_out;
    logic            bin_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int    exp_q[$];
    int    tol_q[$];
    string req_q[$];

    flash_gray_decoder #(.N(N)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .naive_sel (naive_sel),
        .thermo    (thermo),
        .bin_out   (bin_out),
        .bin_valid (bin_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [TAPS-1:0] therm(input int v);
        logic [TAPS-1:0] t;
        t = '0;
        for (int i = 0; i < v; i++) t[i] = 1'b1;
        return t;
    endfunction

    function automatic int naive_ref(input logic [TAPS-1:0] t);
        int r;
        logic up;
        r = 0;
        for (int i = 0; i < TAPS; i++) begin
            up = (i + 1 < TAPS) ? t[i+1] : 1'b0;
            if (t[i] && !up) r = r | (i + 1);
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%0d expected=%0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic drive(input logic [TAPS-1:0] t, input logic m,
                         input int e, input int tol, input string req);
        @(posedge clk);
        #1;
        thermo    = t;
        naive_sel = m;
        exp_q.push_back(e);
        tol_q.push_back(tol);
        req_q.push_back(req);
    endtask

    // monitor: outputs change on the rising edge, sampled just after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (bin_valid && exp_q.size() > 0) begin
                int e, tol, got, diff;
                string req;
                e   = exp_q.pop_front();
                tol = tol_q.pop_front();
                req = req_q.pop_front();
                got = int'(bin_out);
                diff = (got > e) ? got - e : e - got;
                check(diff <= tol, req, got, e);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R6: reset state with a full-scale vector applied
        repeat (3) @(posedge clk);
        @(negedge clk);
        #2;
        check(bin_out == '0, "R6 reset output", int'(bin_out), 0);
        check(bin_valid == 1'b0, "R6 reset valid", int'(bin_valid), 0);

        // release; the first captured sample is the zero vector (R1)
        @(posedge clk);
        #1;
        rst_n     = 1'b1;
        thermo    = '0;
        naive_sel = 1'b0;
        exp_q.push_back(0);
        tol_q.push_back(0);
        req_q.push_back("R1 all-zero");
        @(negedge clk);
        #2;
        check(bin_valid == 1'b0, "R6 valid before first output edge", int'(bin_valid), 0);

        // R2: Gray-mode sweep of every well-formed vector, ending at full scale (R1)
        for (int v = 1; v <= int'(TAPS); v++)
            drive(therm(v), 1'b0, v, 0, (v == int'(TAPS)) ? "R1 all-one" : "R2 gray sweep");

        // R7: comparison-mode sweep of well-formed vectors
        for (int v = 0; v <= int'(TAPS); v++)
            drive(therm(v), 1'b1, v, 0, "R7 naive sweep");

        // R8: one wrong decision at the transition, Gray mode
        for (int v = 1; v < int'(TAPS); v++) begin
            logic [TAPS-1:0] lo, hi;
            lo = therm(v);
            lo[v-1] = 1'b0;
            hi = therm(v);
            hi[v] = 1'b1;
            drive(lo, 1'b0, v, 1, "R8 top one cleared");
            drive(hi, 1'b0, v, 1, "R8 lowest zero set");
        end

        // R7: gap just below the top one at mid-scale gives a large error
        begin
            logic [TAPS-1:0] gap;
            int mid;
            mid = 2**(N-1);
            gap = therm(mid);
            gap[mid-2] = 1'b0;
            drive(gap, 1'b1, naive_ref(gap), 0, "R7 mid-scale gap");
            if (naive_ref(gap) - mid < int'(FULL) / 2 - 2)
                check(1'b0, "R7 gap size", naive_ref(gap) - mid, int'(FULL) / 2);
        end

        // R9: mode toggles every cycle; Gray gets well-formed, comparison gets gapped vectors
        for (int j = 0; j < 40; j++) begin
            int v;
            logic [TAPS-1:0] t;
            v = 3 + ((j * 11) % (int'(TAPS) - 3));
            t = therm(v);
            if (j % 2 == 1) begin
                t[v-2] = 1'b0;
                drive(t, 1'b1, naive_ref(t), 0, "R9 toggle naive");
            end else begin
                drive(t, 1'b0, v, 0, "R9 toggle gray");
            end
        end

        // R5: every sample has come out one cycle after capture and nothing is left
        repeat (2) @(negedge clk);
        #2;
        check(exp_q.size() == 0, "R5 all samples delivered", exp_q.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule